// File: doc/BRIEF.md
# PWM Fault Input Protection Controller

The block watches four external fault pins for a complementary PWM channel pair. Each pin is brought into the system clock domain and given a per-pin active level. It can then pass through a glitch filter whose window is shared by all pins. A rising edge of the cleaned, active-high signal sets a sticky per-pin flag. The flags are combined into a summary flag and an interrupt request. Software clears a flag through a read-then-write-zero handshake.

A fault event is a rising edge on the combined level of the enabled pins while fault control is on. If the pair's protection enable is set, the event forces both PWM outputs to their configured safe levels. The override stays in place until every flag has been cleared and the combined level has gone inactive. The PWM waveforms are made elsewhere: they enter on `pwm_i`, and `pwm_o` carries them on, or the safe levels while the override holds.

Top module: `pwm_fault_guard`

## Requirements
- R1: With the filter bypassed, a fault flag is set on the third rising clock edge after its pin becomes active (two synchroniser stages plus the flag register). It is still clear after the second edge.
- R2: Polarity bit 0 makes a high pin level the active fault level. Polarity bit 1 makes a low pin level active.
- R3: When the filter enable of a pin is 1 and the shared filter value V is nonzero, the active level reaches edge detection only after it has been present on 4·V consecutive clock edges. A pulse of 4·V−1 cycles is dropped. With V = 0 or the pin's filter enable 0, the filter is bypassed and a one-cycle pulse sets the flag.
- R4: A flag is set only when the 2-bit mode field is nonzero and that pin's enable bit is 1. Mode 0 or a disabled pin leaves the flag clear.
- R5: Flags are sticky: a flag stays set after its pin returns to the inactive level.
- R6: A write strobe clears flag bit i only when bit i of the write data is 0 and a read strobe was seen while that flag was 1, after the previous write. Every write consumes the read qualification, and writing 1 leaves a flag unchanged.
- R7: When a new rising edge sets a flag on the same clock edge that a qualified write of 0 clears it, the flag remains set.
- R8: `fault_any_o` is the OR of the four flags. `irq_o` equals `fault_any_o` AND `irq_en_i`.
- R9: `fault_lvl_o` is the OR of the enabled, polarity-corrected, filtered pin levels, independent of the mode field.
- R10: A fault event with `pair_en_i` = 1 drives `pwm_o` to `safe_lvl_i` from the same clock edge that sets the flag. With `pair_en_i` = 0, `pwm_o` follows `pwm_i`.
- R11: The override is released on the clock edge after all flags are clear and `fault_lvl_o` is 0. Until then it holds even if the flags are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fault_pin_i | input | 4 | Raw fault pins |
| mode_i | input | 2 | Fault control mode; nonzero turns fault control on |
| in_en_i | input | 4 | Per-pin enable |
| pol_i | input | 4 | Per-pin polarity (1 = low active) |
| filt_en_i | input | 4 | Per-pin filter enable |
| filt_val_i | input | 4 | Shared filter value V |
| pair_en_i | input | 1 | Pair output override enable |
| safe_lvl_i | input | 2 | Safe output levels for channels n and n+1 |
| pwm_i | input | 2 | PWM outputs from the generator |
| pwm_o | output | 2 | PWM outputs after protection |
| irq_en_i | input | 1 | Fault interrupt enable |
| flag_rd_i | input | 1 | Read strobe on the flag register |
| flag_wr_i | input | 1 | Write strobe on the flag register |
| flag_wdata_i | input | 4 | Write data for the flags |
| flags_o | output | 4 | Per-pin fault flags |
| fault_any_o | output | 1 | Summary fault flag |
| fault_lvl_o | output | 1 | Combined level of enabled pins |
| irq_o | output | 1 | Fault interrupt request |

## Verification
The two functions that can collide are a flag being set by a fresh edge and the same flag being cleared by a qualified write of 0. The bench first sets and read-qualifies a flag, then raises the pin again. It places the write strobe so that it meets the third clock edge after the pin change, the edge on which the new rising edge reaches the flag. The flag must read 1 afterwards. A control run with the same write and no new edge must clear it.

// File: rtl/pwm_fault_pkg.sv
package pwm_fault_pkg;
  localparam int unsigned N_IN_DEF = 4;
  localparam int unsigned FV_W_DEF = 4;
  localparam int unsigned SYNC_DEF = 2;
  localparam int unsigned PAIR_W   = 2;

  typedef enum logic [1:0] {
    FM_OFF  = 2'd0,
    FM_M1   = 2'd1,
    FM_M2   = 2'd2,
    FM_M3   = 2'd3
  } fault_mode_e;

  function automatic logic mode_active(input logic [1:0] m);
    return fault_mode_e'(m) != FM_OFF;
  endfunction
endpackage

// File: rtl/fault_in_path.sv
module fault_in_path #(
  parameter int unsigned FV_W  = 4,
  parameter int unsigned SYNC  = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pin_i,
  input  logic            pol_i,
  input  logic            filt_en_i,
  input  logic [FV_W-1:0] filt_val_i,
  output logic            lvl_o,
  output logic            rise_o
);
  localparam int unsigned CNT_W = FV_W + 2;

  logic [SYNC-1:0]  sync_q;
  logic             act;
  logic             bypass;
  logic [CNT_W-1:0] lim;
  logic [CNT_W-1:0] cnt_q;
  logic             hold_q;
  logic             filt;
  logic             prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC-2:0], pin_i};
  end

  assign act    = sync_q[SYNC-1] ^ pol_i;
  assign bypass = !filt_en_i || (filt_val_i == '0);
  assign lim    = {filt_val_i, 2'b00};

  // filtered level: tracks act in bypass so switching modes is glitch-free
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= 1'b0;
      cnt_q  <= '0;
    end else if (bypass) begin
      hold_q <= act;
      cnt_q  <= '0;
    end else if (act == hold_q) begin
      cnt_q  <= '0;
    end else if (cnt_q == lim - CNT_W'(1)) begin
      hold_q <= act;
      cnt_q  <= '0;
    end else begin
      cnt_q  <= cnt_q + CNT_W'(1);
    end
  end

  assign filt = bypass ? act : hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= filt;
  end

  assign lvl_o  = filt;
  assign rise_o = filt & ~prev_q;

  // R3
  filt_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$stable(hold_q) && $past(!bypass))
      |-> $past(cnt_q == lim - CNT_W'(1)));
endmodule

// File: rtl/fault_flag_bank.sv
module fault_flag_bank #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         rd_i,
  input  logic         wr_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] flags_o,
  output logic         any_o
);
  logic [N-1:0] flags_q;
  logic [N-1:0] armed_q;
  logic [N-1:0] clr;

  assign clr = {N{wr_i}} & armed_q & ~wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      armed_q <= '0;
    end else begin
      flags_q <= set_i | (flags_q & ~clr);
      if (rd_i)      armed_q <= flags_q;
      else if (wr_i) armed_q <= '0;
    end
  end

  assign flags_o = flags_q;
  assign any_o   = |flags_q;

  for (genvar g = 0; g < N; g++) begin : g_chk
    // R6
    flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && $fell(flags_q[g]))
        |-> $past(wr_i && !wdata_i[g] && armed_q[g]));
    // R7
    flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && $past(set_i[g])) |-> flags_q[g]);
  end
endmodule

// File: rtl/pair_override.sv
module pair_override #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         event_i,
  input  logic         pair_en_i,
  input  logic         any_i,
  input  logic         lvl_i,
  input  logic [W-1:0] safe_i,
  input  logic [W-1:0] pwm_i,
  output logic [W-1:0] pwm_o
);
  logic hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      hold_q <= 1'b0;
    else if (event_i && pair_en_i)    hold_q <= 1'b1;
    else if (!any_i && !lvl_i)        hold_q <= 1'b0;
  end

  assign pwm_o = hold_q ? safe_i : pwm_i;

  // R10
  force_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(event_i && pair_en_i)) |-> hold_q);
  // R11
  force_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $fell(hold_q)) |-> $past(!any_i && !lvl_i));
endmodule

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard
  import pwm_fault_pkg::*;
#(
  parameter int unsigned N_IN = N_IN_DEF,
  parameter int unsigned FV_W = FV_W_DEF,
  parameter int unsigned SYNC = SYNC_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_IN-1:0]   fault_pin_i,
  input  logic [1:0]        mode_i,
  input  logic [N_IN-1:0]   in_en_i,
  input  logic [N_IN-1:0]   pol_i,
  input  logic [N_IN-1:0]   filt_en_i,
  input  logic [FV_W-1:0]   filt_val_i,
  input  logic              pair_en_i,
  input  logic [PAIR_W-1:0] safe_lvl_i,
  input  logic [PAIR_W-1:0] pwm_i,
  output logic [PAIR_W-1:0] pwm_o,
  input  logic              irq_en_i,
  input  logic              flag_rd_i,
  input  logic              flag_wr_i,
  input  logic [N_IN-1:0]   flag_wdata_i,
  output logic [N_IN-1:0]   flags_o,
  output logic              fault_any_o,
  output logic              fault_lvl_o,
  output logic              irq_o
);
  logic [N_IN-1:0] lvl;
  logic [N_IN-1:0] rise;
  logic [N_IN-1:0] set;
  logic            mode_on;
  logic            lvl_q;
  logic            fault_evt;

  for (genvar g = 0; g < N_IN; g++) begin : g_in
    fault_in_path #(.FV_W(FV_W), .SYNC(SYNC)) u_path (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pin_i      (fault_pin_i[g]),
      .pol_i      (pol_i[g]),
      .filt_en_i  (filt_en_i[g]),
      .filt_val_i (filt_val_i),
      .lvl_o      (lvl[g]),
      .rise_o     (rise[g])
    );
  end

  assign mode_on     = mode_active(mode_i);
  assign set         = rise & in_en_i & {N_IN{mode_on}};
  assign fault_lvl_o = |(lvl & in_en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= fault_lvl_o;
  end

  assign fault_evt = mode_on & fault_lvl_o & ~lvl_q;

  fault_flag_bank #(.N(N_IN)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (set),
    .rd_i    (flag_rd_i),
    .wr_i    (flag_wr_i),
    .wdata_i (flag_wdata_i),
    .flags_o (flags_o),
    .any_o   (fault_any_o)
  );

  pair_override #(.W(PAIR_W)) u_ovr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .event_i   (fault_evt),
    .pair_en_i (pair_en_i),
    .any_i     (fault_any_o),
    .lvl_i     (fault_lvl_o),
    .safe_i    (safe_lvl_i),
    .pwm_i     (pwm_i),
    .pwm_o     (pwm_o)
  );

  assign irq_o = fault_any_o & irq_en_i;

  // R4
  flag_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $rose(fault_any_o)) |-> $past(mode_on && |in_en_i));
endmodule

// File: tb/pwm_fault_guard_tb.sv
module pwm_fault_guard_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] pin = '0, in_en = '0, pol = '0, fen = '0, fval = '0, wdata = '0;
  logic [1:0] mode = 2'd1, safe = 2'b10, pwm_in = 2'b01, pwm_out;
  logic       pair_en = 1'b0, irq_en = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [3:0] flags;
  logic       any, lvl, irq;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwm_fault_guard u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .fault_pin_i(pin), .mode_i(mode),
    .in_en_i(in_en), .pol_i(pol), .filt_en_i(fen), .filt_val_i(fval),
    .pair_en_i(pair_en), .safe_lvl_i(safe), .pwm_i(pwm_in), .pwm_o(pwm_out),
    .irq_en_i(irq_en), .flag_rd_i(rd), .flag_wr_i(wr), .flag_wdata_i(wdata),
    .flags_o(flags), .fault_any_o(any), .fault_lvl_o(lvl), .irq_o(irq)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // pins idle at inactive level (inactive pin value equals polarity bit)
  task automatic do_reset(input logic [3:0] p);
    rst_ni = 1'b0; pol = p; pin = p; in_en = '0; pair_en = 1'b0; mode = 2'd1;
    fen = '0; fval = '0; rd = 1'b0; wr = 1'b0; wdata = '0; irq_en = 1'b0;
    pwm_in = 2'b01; safe = 2'b10;
    step(2); rst_ni = 1'b1; step(4);
  endtask

  task automatic pulse(input logic [3:0] m, input int w);
    pin = pin ^ m; step(w); pin = pin ^ m;
  endtask

  task automatic clear(input logic [3:0] w);
    rd = 1'b1; step(1); rd = 1'b0;
    wr = 1'b1; wdata = w; step(1); wr = 1'b0;
  endtask

  initial begin
    do_reset('0);
    check("R8 reset flags", flags, 0);
    check("R8 reset irq", irq, 0);
    check("R10 reset pass", pwm_out, 1);
    check("R9 reset lvl", lvl, 0);

    // R1 R2 R5 R8 R9: every pin, both polarities
    for (int p = 0; p < 2; p++) begin
      for (int i = 0; i < 4; i++) begin
        do_reset({4{p[0]}});
        in_en = 4'hF; step(1);
        pin[i] = ~pin[i];
        step(2);
        check("R1 not yet", flags, 0);
        check("R9 lvl", lvl, 1);
        step(1);
        check("R2 flag", flags, 1 << i);
        check("R8 any", any, 1);
        pin[i] = ~pin[i]; step(4);
        check("R5 sticky", flags, 1 << i);
        check("R9 lvl low", lvl, 0);
      end
    end

    // R4 R9: mode and enable sweep
    for (int m = 0; m < 4; m++) begin
      for (int e = 0; e < 2; e++) begin
        do_reset('0);
        mode = m[1:0]; in_en[0] = e[0]; step(1);
        pin[0] = 1'b1; step(3);
        check("R4 gate", flags[0], (m != 0 && e != 0) ? 1 : 0);
        check("R9 lvl en", lvl, e);
      end
    end

    // R3: filter sweep
    for (int v = 1; v < 4; v++) begin
      for (int fe = 0; fe < 2; fe++) begin
        do_reset('0);
        in_en = 4'hF; fval = v[3:0]; fen[1] = fe[0]; step(1);
        pulse(4'b0010, 4 * v - 1); step(4 * v + 8);
        check("R3 short", flags[1], fe ? 0 : 1);
        pulse(4'b0010, 4 * v); step(4 * v + 8);
        check("R3 full", flags[1], 1);
      end
    end
    do_reset('0);
    in_en = 4'hF; fval = 4'd0; fen = 4'hF; step(1);
    pulse(4'b0100, 1); step(4);
    check("R3 zero bypass", flags[2], 1);
    do_reset('0);
    in_en = 4'hF; fval = 4'd2; fen = 4'hF; step(1);
    pin[3] = 1'b1; step(2 + 8);
    check("R3 latency early", flags[3], 0);
    step(1);
    check("R3 latency", flags[3], 1);

    // R6: clear handshake
    do_reset('0);
    in_en = 4'hF; step(1);
    pulse(4'b0100, 1); step(4);
    wr = 1'b1; wdata = 4'h0; step(1); wr = 1'b0;
    check("R6 unarmed write", flags, 4);
    clear(4'hF);
    check("R6 write one", flags, 4);
    wr = 1'b1; wdata = 4'h0; step(1); wr = 1'b0;
    check("R6 consumed", flags, 4);
    clear(4'h0);
    check("R6 cleared", flags, 0);
    pulse(4'b1001, 1); step(4);
    clear(4'b0111);
    check("R6 selective", flags, 1);

    // R8: interrupt
    do_reset('0);
    in_en = 4'hF; step(1);
    pulse(4'b1000, 1); step(4);
    check("R8 irq off", irq, 0);
    check("R8 any set", any, 1);
    irq_en = 1'b1; step(1);
    check("R8 irq on", irq, 1);
    clear(4'h0);
    check("R8 irq cleared", irq, 0);
    check("R8 any cleared", any, 0);

    // R7: set and clear on the same edge
    do_reset('0);
    in_en = 4'hF; step(1);
    pulse(4'b0001, 1); step(4);
    rd = 1'b1; step(1); rd = 1'b0;
    pin[0] = 1'b1; step(2);
    wr = 1'b1; wdata = 4'h0; step(1); wr = 1'b0;
    check("R7 set wins", flags[0], 1);
    pin[0] = 1'b0; step(4);
    clear(4'h0);
    check("R7 control clear", flags[0], 0);

    // R10 R11: override
    do_reset('0);
    in_en = 4'hF; pair_en = 1'b1; step(1);
    pin[0] = 1'b1; step(2);
    check("R10 before", pwm_out, 1);
    step(1);
    check("R10 forced", pwm_out, 2);
    pin[0] = 1'b0; step(3);
    pwm_in = 2'b11; step(1);
    check("R10 held", pwm_out, 2);
    rd = 1'b1; step(1); rd = 1'b0;
    wr = 1'b1; wdata = 4'h0; step(1); wr = 1'b0;
    check("R11 still forced", pwm_out, 2);
    step(1);
    check("R11 released", pwm_out, 3);
    pin[1] = 1'b1; step(3);
    check("R10 forced again", pwm_out, 2);
    clear(4'h0); step(3);
    check("R11 level holds", pwm_out, 2);
    pin[1] = 1'b0; step(2);
    check("R11 level hold edge", pwm_out, 2);
    step(1);
    check("R11 level released", pwm_out, 3);
    do_reset('0);
    in_en = 4'hF; step(1);
    pin[2] = 1'b1; step(3);
    check("R10 disabled flag", flags, 4);
    check("R10 disabled pass", pwm_out, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule